// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

A purely combinational arithmetic and logic unit for a small accumulator-style microcontroller datapath. One operand comes from the register file or from an instruction literal (`file_i`). The other operand is always the working register (`wreg_i`). A separate bit mask (`mask_i`) serves the single-bit set and clear operations. The incoming carry flag (`carry_i`) feeds the rotates.

The unit returns the result together with carry, digit-carry and zero indications. It also returns a 3-bit update mask. The surrounding status logic uses that mask to decide which of the three flags the current operation overwrites. Decoding, storage of the flags and any control flow stay outside the block. Results settle in the same cycle the inputs are applied.

Top module: `acc_alu`

## Requirements
- R1: `op_i` encodings are ADD=0, SUB=1, AND=2, IOR=3, XOR=4, NOT=5, INC=6, DEC=7, CLR=8, MOV=9, MOVW=10, RLF=11, RRF=12, SWAP=13, BCF=14, BSF=15. ADD gives `result_o` = (`file_i` + `wreg_i`) mod 256. It sets `carry_o` to the carry out of bit 7 and `dcarry_o` to the carry out of bit 3.
- R2: SUB gives `file_i` − `wreg_i` mod 256. `carry_o` is 1 when `file_i` >= `wreg_i` (no borrow). `dcarry_o` is 1 when `file_i[3:0]` >= `wreg_i[3:0]` (no borrow out of bit 3).
- R3: AND, IOR and XOR combine `file_i` with `wreg_i` bitwise. NOT returns the bitwise complement of `file_i`.
- R4: INC gives `file_i`+1 and DEC gives `file_i`−1, both wrapping modulo 256, so 0xFF becomes 0x00 and 0x00 becomes 0xFF. CLR gives 0x00.
- R5: MOV returns `file_i` unchanged and MOVW returns `wreg_i` unchanged.
- R6: RLF returns {`file_i[6:0]`, `carry_i`} with `carry_o` = `file_i[7]`. RRF returns {`carry_i`, `file_i[7:1]`} with `carry_o` = `file_i[0]`.
- R7: SWAP returns `file_i` with bits 7:4 and bits 3:0 exchanged.
- R8: BCF returns `file_i` AND NOT `mask_i`. BSF returns `file_i` OR `mask_i`.
- R9: `zero_o` is 1 exactly when `result_o` is 0x00, for every operation.
- R10: `upd_o` is ordered {Z, DC, C}. It is 3'b111 for ADD and SUB, and 3'b001 for RLF and RRF. It is 3'b100 for AND, IOR, XOR, NOT, INC, DEC, CLR and MOV. It is 3'b000 for SWAP, MOVW, BCF and BSF.
- R11: For operations whose `upd_o` C bit is 0, `carry_o` equals `carry_i`. For operations whose DC bit is 0, `dcarry_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| file_i | input | 8 | Register-file or literal operand |
| wreg_i | input | 8 | Working-register operand |
| mask_i | input | 8 | Bit mask for bit set / bit clear |
| carry_i | input | 1 | Current carry flag |
| op_i | input | 4 | Operation code |
| result_o | output | 8 | Operation result |
| carry_o | output | 1 | Carry / no-borrow / rotated-out bit |
| dcarry_o | output | 1 | Digit carry / no digit borrow |
| zero_o | output | 1 | Result is zero |
| upd_o | output | 3 | Flags to overwrite, {Z, DC, C} |

## Verification
Every result, flag and update-mask output is due in the same cycle as the stimulus, because no register lies between any input and any output. The bench therefore drives operands on the falling clock edge and samples one time unit later. This keeps each comparison well clear of the rising edge and of any input change. Directed scenarios cover the nibble and byte carry boundaries, both wrap cases, and both carry-in values through the rotates. A random sweep over all sixteen operations compares every output against a bench-side model.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_IOR  = 4'd3,
    OP_XOR  = 4'd4,
    OP_NOT  = 4'd5,
    OP_INC  = 4'd6,
    OP_DEC  = 4'd7,
    OP_CLR  = 4'd8,
    OP_MOV  = 4'd9,
    OP_MOVW = 4'd10,
    OP_RLF  = 4'd11,
    OP_RRF  = 4'd12,
    OP_SWAP = 4'd13,
    OP_BCF  = 4'd14,
    OP_BSF  = 4'd15
  } alu_op_e;

  localparam int FLG_C  = 0;
  localparam int FLG_DC = 1;
  localparam int FLG_Z  = 2;
  localparam int FLG_W  = 3;
endpackage

// File: rtl/alu_nib_adder.sv
// Two-segment adder: low half exposes the digit carry.
module alu_nib_adder #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              c_o,
  output logic              dc_o
);
  localparam int LO_W = DATA_W / 2;
  localparam int HI_W = DATA_W - LO_W;

  logic [LO_W:0] lo_sum;
  logic [HI_W:0] hi_sum;

  assign lo_sum = {1'b0, a_i[LO_W-1:0]} + {1'b0, b_i[LO_W-1:0]} + {{LO_W{1'b0}}, cin_i};
  assign hi_sum = {1'b0, a_i[DATA_W-1:LO_W]} + {1'b0, b_i[DATA_W-1:LO_W]}
                + {{HI_W{1'b0}}, lo_sum[LO_W]};

  assign sum_o = {hi_sum[HI_W-1:0], lo_sum[LO_W-1:0]};
  assign dc_o  = lo_sum[LO_W];
  assign c_o   = hi_sum[HI_W];
endmodule

// File: rtl/alu_misc_unit.sv
// Non-arithmetic results: logic, moves, rotates, swap, bit ops.
module alu_misc_unit
  import alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] w_i,
  input  logic [DATA_W-1:0] m_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] res_o,
  output logic              rot_c_o
);
  localparam int LO_W = DATA_W / 2;

  always_comb begin
    res_o   = '0;
    rot_c_o = cin_i;
    unique case (op_i)
      OP_AND:  res_o = a_i & w_i;
      OP_IOR:  res_o = a_i | w_i;
      OP_XOR:  res_o = a_i ^ w_i;
      OP_NOT:  res_o = ~a_i;
      OP_MOV:  res_o = a_i;
      OP_MOVW: res_o = w_i;
      OP_RLF: begin
        res_o   = {a_i[DATA_W-2:0], cin_i};
        rot_c_o = a_i[DATA_W-1];
      end
      OP_RRF: begin
        res_o   = {cin_i, a_i[DATA_W-1:1]};
        rot_c_o = a_i[0];
      end
      OP_SWAP: res_o = {a_i[LO_W-1:0], a_i[DATA_W-1:LO_W]};
      OP_BCF:  res_o = a_i & ~m_i;
      OP_BSF:  res_o = a_i | m_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_upd_dec.sv
// Per-operation flag overwrite mask, {Z, DC, C}.
module alu_upd_dec
  import alu_pkg::*;
(
  input  alu_op_e          op_i,
  output logic [FLG_W-1:0] upd_o
);
  always_comb begin
    upd_o = '0;
    unique case (op_i)
      OP_ADD, OP_SUB: begin
        upd_o[FLG_C]  = 1'b1;
        upd_o[FLG_DC] = 1'b1;
        upd_o[FLG_Z]  = 1'b1;
      end
      OP_RLF, OP_RRF:
        upd_o[FLG_C] = 1'b1;
      OP_AND, OP_IOR, OP_XOR, OP_NOT, OP_INC, OP_DEC, OP_CLR, OP_MOV:
        upd_o[FLG_Z] = 1'b1;
      default: upd_o = '0;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] file_i,
  input  logic [DATA_W-1:0] wreg_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic              carry_i,
  input  logic [3:0]        op_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o,
  output logic              dcarry_o,
  output logic              zero_o,
  output logic [FLG_W-1:0]  upd_o
);
  alu_op_e           op;
  logic [DATA_W-1:0] add_b;
  logic              add_cin;
  logic [DATA_W-1:0] add_sum;
  logic              add_c;
  logic              add_dc;
  logic [DATA_W-1:0] misc_res;
  logic              rot_c;
  logic              is_arith;
  logic              is_full;
  logic              is_rot;

  assign op = alu_op_e'(op_i);

  // One adder serves ADD, SUB, INC and DEC via operand steering.
  always_comb begin
    add_b   = '0;
    add_cin = 1'b0;
    unique case (op)
      OP_ADD: add_b = wreg_i;
      OP_SUB: begin
        add_b   = ~wreg_i;
        add_cin = 1'b1;
      end
      OP_INC: add_cin = 1'b1;
      OP_DEC: add_b = '1;
      default: add_b = '0;
    endcase
  end

  alu_nib_adder #(.DATA_W(DATA_W)) u_add (
    .a_i   (file_i),
    .b_i   (add_b),
    .cin_i (add_cin),
    .sum_o (add_sum),
    .c_o   (add_c),
    .dc_o  (add_dc)
  );

  alu_misc_unit #(.DATA_W(DATA_W)) u_misc (
    .op_i    (op),
    .a_i     (file_i),
    .w_i     (wreg_i),
    .m_i     (mask_i),
    .cin_i   (carry_i),
    .res_o   (misc_res),
    .rot_c_o (rot_c)
  );

  alu_upd_dec u_upd (
    .op_i  (op),
    .upd_o (upd_o)
  );

  assign is_full  = (op == OP_ADD) || (op == OP_SUB);
  assign is_arith = is_full || (op == OP_INC) || (op == OP_DEC);
  assign is_rot   = (op == OP_RLF) || (op == OP_RRF);

  assign result_o = is_arith ? add_sum : misc_res;
  assign carry_o  = is_full ? add_c : (is_rot ? rot_c : carry_i);
  assign dcarry_o = is_full & add_dc;
  assign zero_o   = (result_o == '0);
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic [DATA_W-1:0] file_i,
  input logic [DATA_W-1:0] wreg_i,
  input logic [DATA_W-1:0] mask_i,
  input logic              carry_i,
  input logic [3:0]        op_i,
  input logic [DATA_W-1:0] result_o,
  input logic              carry_o,
  input logic              dcarry_o,
  input logic              zero_o,
  input logic [FLG_W-1:0]  upd_o
);
  logic [DATA_W:0] add_ref;
  assign add_ref = {1'b0, file_i} + {1'b0, wreg_i};

  always_comb begin
    // R1
    if (op_i == OP_ADD) add_sum_chk: assert ({carry_o, result_o} == add_ref);
    // R6
    if (op_i == OP_RLF) rlf_carry_chk: assert (carry_o == file_i[DATA_W-1] && result_o[0] == carry_i);
    // R8
    if (op_i == OP_BSF) bsf_mask_chk: assert ((result_o & mask_i) == mask_i);
    // R9
    zero_flag_chk: assert (zero_o == (result_o == '0));
    // R10
    if (op_i == OP_SWAP || op_i == OP_MOVW || op_i == OP_BCF || op_i == OP_BSF)
      no_upd_chk: assert (upd_o == 3'b000);
    // R11
    if (!upd_o[FLG_C]) keep_carry_chk: assert (carry_o == carry_i);
    // R11
    if (!upd_o[FLG_DC]) dc_clear_chk: assert (!dcarry_o);
  end
endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/acc_alu_test.sv
module acc_alu_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic [7:0] file_i = '0, wreg_i = '0, mask_i = '0;
  logic       carry_i = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] result_o;
  logic       carry_o, dcarry_o, zero_o;
  logic [2:0] upd_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  acc_alu uut (
    .file_i(file_i), .wreg_i(wreg_i), .mask_i(mask_i), .carry_i(carry_i), .op_i(op_i),
    .result_o(result_o), .carry_o(carry_o), .dcarry_o(dcarry_o), .zero_o(zero_o), .upd_o(upd_o)
  );

  // Model from the requirements: {res[7:0], c, dc, z, upd[2:0]}
  function automatic logic [13:0] model(input logic [3:0] op, input logic [7:0] a, w, m,
                                        input logic ci);
    logic [7:0] r;
    logic c, dc;
    logic [2:0] u;
    c = ci; dc = 1'b0; r = 8'h00; u = 3'b000;
    case (op)
      4'd0: begin r = a + w; c = (int'(a) + int'(w)) > 255;
                  dc = (int'(a[3:0]) + int'(w[3:0])) > 15; u = 3'b111; end
      4'd1: begin r = a - w; c = a >= w; dc = a[3:0] >= w[3:0]; u = 3'b111; end
      4'd2: begin r = a & w; u = 3'b100; end
      4'd3: begin r = a | w; u = 3'b100; end
      4'd4: begin r = a ^ w; u = 3'b100; end
      4'd5: begin r = ~a; u = 3'b100; end
      4'd6: begin r = a + 8'd1; u = 3'b100; end
      4'd7: begin r = a - 8'd1; u = 3'b100; end
      4'd8: begin r = 8'h00; u = 3'b100; end
      4'd9: begin r = a; u = 3'b100; end
      4'd10: r = w;
      4'd11: begin r = {a[6:0], ci}; c = a[7]; u = 3'b001; end
      4'd12: begin r = {ci, a[7:1]}; c = a[0]; u = 3'b001; end
      4'd13: r = {a[3:0], a[7:4]};
      4'd14: r = a & ~m;
      default: r = a | m;
    endcase
    return {r, c, dc, (r == 8'h00), u};
  endfunction

  task automatic run_vec(input logic [3:0] op, input logic [7:0] a, w, m, input logic ci,
                         input string req);
    logic [13:0] exp_v, act_v;
    @(negedge clk);
    op_i = op; file_i = a; wreg_i = w; mask_i = m; carry_i = ci;
    #1;
    exp_v = model(op, a, w, m, ci);
    act_v = {result_o, carry_o, dcarry_o, zero_o, upd_o};
    n_run++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h w=%h m=%h ci=%b: actual res=%h c=%b dc=%b z=%b upd=%b expected res=%h c=%b dc=%b z=%b upd=%b",
               req, op, a, w, m, ci, act_v[13:6], act_v[5], act_v[4], act_v[3], act_v[2:0],
               exp_v[13:6], exp_v[5], exp_v[4], exp_v[3], exp_v[2:0]);
    end
  endtask

  task automatic t_idle;
    run_vec(4'd8, 8'h5A, 8'hA5, 8'h00, 1'b0, "R4 clr");
    run_vec(4'd9, 8'h00, 8'h00, 8'h00, 1'b0, "R9 zero");
  endtask

  task automatic t_add;
    run_vec(4'd0, 8'h0F, 8'h01, 8'h00, 1'b0, "R1 nibble carry");
    run_vec(4'd0, 8'hFF, 8'h01, 8'h00, 1'b0, "R1 byte wrap");
    run_vec(4'd0, 8'h80, 8'h80, 8'h00, 1'b1, "R1 carry no dc");
    run_vec(4'd0, 8'h12, 8'h34, 8'h00, 1'b1, "R1 plain");
  endtask

  task automatic t_sub;
    run_vec(4'd1, 8'h05, 8'h05, 8'h00, 1'b0, "R2 equal");
    run_vec(4'd1, 8'h10, 8'h01, 8'h00, 1'b0, "R2 digit borrow");
    run_vec(4'd1, 8'h00, 8'h01, 8'h00, 1'b1, "R2 borrow");
    run_vec(4'd1, 8'h3C, 8'h21, 8'h00, 1'b0, "R2 plain");
  endtask

  task automatic t_logic;
    run_vec(4'd2, 8'hF0, 8'h3C, 8'h00, 1'b0, "R3 and");
    run_vec(4'd2, 8'hF0, 8'h0F, 8'h00, 1'b1, "R3 and zero");
    run_vec(4'd3, 8'hA0, 8'h05, 8'h00, 1'b0, "R3 ior");
    run_vec(4'd4, 8'hFF, 8'hFF, 8'h00, 1'b1, "R3 xor zero");
    run_vec(4'd5, 8'hFF, 8'h00, 8'h00, 1'b0, "R3 not");
  endtask

  task automatic t_incdec;
    run_vec(4'd6, 8'hFF, 8'h00, 8'h00, 1'b1, "R4 inc wrap");
    run_vec(4'd6, 8'h0F, 8'h00, 8'h00, 1'b0, "R4 inc");
    run_vec(4'd7, 8'h00, 8'h00, 8'h00, 1'b0, "R4 dec wrap");
    run_vec(4'd7, 8'h01, 8'h00, 8'h00, 1'b1, "R4 dec to zero");
  endtask

  task automatic t_pass;
    run_vec(4'd9, 8'h96, 8'h11, 8'h00, 1'b0, "R5 mov");
    run_vec(4'd10, 8'h11, 8'h00, 8'h00, 1'b1, "R5 movw zero");
    run_vec(4'd10, 8'h11, 8'hC3, 8'h00, 1'b0, "R5 movw");
  endtask

  task automatic t_rotate;
    for (int ci = 0; ci < 2; ci++) begin
      run_vec(4'd11, 8'h81, 8'h00, 8'h00, ci[0], "R6 rlf");
      run_vec(4'd12, 8'h81, 8'h00, 8'h00, ci[0], "R6 rrf");
      run_vec(4'd11, 8'h00, 8'h00, 8'h00, ci[0], "R6 rlf zero");
    end
  endtask

  task automatic t_swap;
    run_vec(4'd13, 8'h3C, 8'h00, 8'h00, 1'b1, "R7 swap");
    run_vec(4'd13, 8'hA1, 8'h00, 8'h00, 1'b0, "R7 swap");
  endtask

  task automatic t_bits;
    for (int b = 0; b < 8; b++) begin
      run_vec(4'd14, 8'hFF, 8'h00, 8'h01 << b, 1'b0, "R8 bcf");
      run_vec(4'd15, 8'h00, 8'h00, 8'h01 << b, 1'b1, "R8 bsf");
    end
  endtask

  task automatic t_keep_flags;
    for (int op = 2; op < 16; op++) begin
      if (op == 11 || op == 12) continue;
      run_vec(op[3:0], 8'hFF, 8'hFF, 8'h00, 1'b1, "R11 carry kept");
      run_vec(op[3:0], 8'h0F, 8'h01, 8'h00, 1'b0, "R11 carry kept");
    end
  endtask

  task automatic t_sweep;
    for (int op = 0; op < 16; op++)
      for (int k = 0; k < 40; k++)
        run_vec(op[3:0], 8'($urandom), 8'($urandom), 8'h01 << ($urandom % 8),
                1'($urandom), "R10 sweep");
  endtask

  initial begin
    t_idle();
    t_add();
    t_sub();
    t_logic();
    t_incdec();
    t_pass();
    t_rotate();
    t_swap();
    t_bits();
    t_keep_flags();
    t_sweep();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule